// File: doc/BRIEF.md
# Upset-Tolerant Serial Key Detector

This block watches a serial bit stream, one bit per clock, and raises a one-cycle `detect` pulse each time the most recent sixteen accepted bits equal a fixed key. Its state register can take a radiation-induced bit flip without any visible change in behaviour. Internally it is a sixteen-state machine. Each state is the number of key bits matched so far, and the next state follows the longest prefix of the key that still matches. Because of this, occurrences that overlap are all reported.

Each state is stored as an 8-bit word from an extended Hamming code, so any two legal words differ in at least four bit positions. On every cycle the register is decoded, and any single-bit error is corrected before the next-state logic sees it. The next state is always written back as a clean codeword, so one flip is scrubbed within one clock. A word with two flipped bits cannot be corrected. In that case the machine drops to the zero-matched state and raises a fatal flag for that cycle. Every one of the 256 register values therefore leads to a defined state, and the machine cannot lock up.

The serial input uses a valid/ready pair. `bit_ready` is high whenever reset is low, and the block never applies back-pressure. A bit is taken on any rising edge where `bit_valid` is high. When `bit_valid` is low, that cycle's `bit_in` is discarded. The input is registered before it reaches the state logic.

Top module: `hd3_pattern_fsm`

## Requirements
- R1: The key is received most significant bit first. `detect` is high for exactly one cycle, the cycle after the rising edge that captures the accepted bit completing sixteen accepted bits equal to `KEY`; otherwise `detect` is low.
- R2: After a mismatch or a detection, matching continues from the longest key prefix that is still a suffix of the accepted bits. For the key 16'hA5A5, the pattern A5A5 followed by A5 gives two pulses eight accepted bits apart.
- R3: A 16-bit word that differs from `KEY` in any single bit position produces no pulse when received after a run of zeros.
- R4: A cycle with `bit_valid` low leaves the match progress unchanged, whatever the value of `bit_in`.
- R5: The state word is laid out as follows: bits [3:0] hold the matched count n; bit 4 = n0^n1^n3; bit 5 = n0^n2^n3; bit 6 = n1^n2^n3; bit 7 = XOR of bits 6:0. Legal words differ pairwise in at least 4 positions.
- R6: With one bit of the state word flipped, `detect` and the next state are the same as with no flip. `err_corrected` is high during that cycle and low in the cycle after it.
- R7: With two bits of the state word flipped, `err_fatal` is high and `detect` is low during that cycle. The bit waiting in the input register is dropped, and the machine restarts from zero matched bits.
- R8: While `rst` is high on a rising edge, the machine goes to zero matched bits and clears the input register. `bit_ready` is low while `rst` is high and high otherwise. `detect`, `err_corrected` and `err_fatal` are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial data bit |
| bit_valid | input | 1 | `bit_in` is offered this cycle |
| bit_ready | output | 1 | Block accepts bits (high whenever reset is low) |
| detect | output | 1 | One-cycle pulse when the key has been completed |
| err_corrected | output | 1 | State word held a single-bit error this cycle |
| err_fatal | output | 1 | State word held an uncorrectable error this cycle |

## Verification
The bench targets the following corner cases:
- Overlapping keys: a design without the prefix fallback would miss the second of two keys that share eight bits.
- Near-miss words with one flipped bit: a design with a loose fallback would report them falsely.
- Gaps where `bit_valid` is low carrying random `bit_in` values: these would corrupt progress if taken.
- Upsets forced into the state register at every bit position, including the cycle in which the key completes: a missing correction would lose or invent a pulse.
- Double upsets: a decoder that mistakes them for single errors would jump to a wrong state instead of restarting and flagging.

// File: rtl/hd3_pkg.sv
package hd3_pkg;
  localparam int KEY_W  = 16;
  localparam int IDX_W  = $clog2(KEY_W);
  localparam int CHK_W  = 4;
  localparam int CODE_W = IDX_W + CHK_W;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [CODE_W-1:0] code_t;

  // Extended Hamming word: count in [3:0], three checks, overall parity on top.
  function automatic code_t hd3_encode(idx_t d);
    code_t c;
    c[3:0] = d;
    c[4]   = d[0] ^ d[1] ^ d[3];
    c[5]   = d[0] ^ d[2] ^ d[3];
    c[6]   = d[1] ^ d[2] ^ d[3];
    c[7]   = ^c[6:0];
    return c;
  endfunction

  // Syndrome produced by an error in data bit i.
  function automatic logic [2:0] hd3_bit_syndrome(int i);
    case (i)
      0:       return 3'b011;
      1:       return 3'b101;
      2:       return 3'b110;
      default: return 3'b111;
    endcase
  endfunction

  // Longest key prefix (below KEY_W) that ends the stream "prefix k, then b".
  function automatic idx_t hd3_fallback(logic [KEY_W-1:0] key, int k, logic b);
    logic [KEY_W:0] s;
    logic [KEY_W:0] pre;
    logic [KEY_W:0] msk;
    int best;
    best = 0;
    s = (({1'b0, key} >> (KEY_W - k)) << 1) | {{KEY_W{1'b0}}, b};
    for (int j = 1; j < KEY_W; j++) begin
      if (j <= k + 1) begin
        pre = {1'b0, key} >> (KEY_W - j);
        msk = (17'(1) << j) - 17'(1);
        if (((s ^ pre) & msk) == '0) best = j;
      end
    end
    return idx_t'(best);
  endfunction
endpackage

// File: rtl/hd3_in_reg.sv
module hd3_in_reg (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic bit_valid,
  output logic bit_q,
  output logic vld_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      bit_q <= bit_in;
      vld_q <= bit_valid;
    end
  end
endmodule

// File: rtl/hd3_decode.sv
module hd3_decode
  import hd3_pkg::*;
(
  input  code_t code,
  output idx_t  idx,
  output logic  single_err,
  output logic  double_err
);
  logic [2:0] syn;
  logic       par;

  assign syn = {code[6] ^ code[1] ^ code[2] ^ code[3],
                code[5] ^ code[0] ^ code[2] ^ code[3],
                code[4] ^ code[0] ^ code[1] ^ code[3]};
  assign par = ^code;

  for (genvar i = 0; i < IDX_W; i++) begin : g_fix
    assign idx[i] = code[i] ^ (par && (syn == hd3_bit_syndrome(i)));
  end

  // Odd parity: exactly one flip. Even parity with nonzero syndrome: two flips.
  assign single_err = par;
  assign double_err = !par && (syn != 3'b000);
endmodule

// File: rtl/hd3_next.sv
module hd3_next
  import hd3_pkg::*;
#(
  parameter logic [KEY_W-1:0] KEY = 16'hA5A5
) (
  input  idx_t  idx,
  input  logic  bit_q,
  input  logic  vld_q,
  input  logic  fatal,
  output code_t code_nxt
);
  idx_t on0 [KEY_W];
  idx_t on1 [KEY_W];
  idx_t nidx;

  for (genvar k = 0; k < KEY_W; k++) begin : g_tbl
    localparam idx_t N0 = hd3_fallback(KEY, k, 1'b0);
    localparam idx_t N1 = hd3_fallback(KEY, k, 1'b1);
    assign on0[k] = N0;
    assign on1[k] = N1;
  end

  always_comb begin
    if (fatal)      nidx = '0;
    else if (vld_q) nidx = bit_q ? on1[idx] : on0[idx];
    else            nidx = idx;
    code_nxt = hd3_encode(nidx);
  end
endmodule

// File: rtl/hd3_pattern_fsm.sv
module hd3_pattern_fsm
  import hd3_pkg::*;
#(
  parameter logic [KEY_W-1:0] KEY = 16'hA5A5
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic bit_valid,
  output logic bit_ready,
  output logic detect,
  output logic err_corrected,
  output logic err_fatal
);
  localparam idx_t LAST = idx_t'(KEY_W - 1);

  logic  in_bit_q;
  logic  in_vld_q;
  code_t state_q;
  code_t code_nxt;
  idx_t  cur_idx;
  logic  sgl;
  logic  dbl;

  hd3_in_reg u_in (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_valid(bit_valid),
    .bit_q(in_bit_q), .vld_q(in_vld_q)
  );

  hd3_decode u_dec (
    .code(state_q), .idx(cur_idx), .single_err(sgl), .double_err(dbl)
  );

  hd3_next #(.KEY(KEY)) u_nxt (
    .idx(cur_idx), .bit_q(in_bit_q), .vld_q(in_vld_q), .fatal(dbl),
    .code_nxt(code_nxt)
  );

  // Plain vector, not an enum, so the written codes stay as they are.
  always_ff @(posedge clk) begin
    if (rst) state_q <= hd3_encode('0);
    else     state_q <= code_nxt;
  end

  assign bit_ready     = !rst;
  assign detect        = in_vld_q && !dbl && (cur_idx == LAST) && (in_bit_q == KEY[0]);
  assign err_corrected = sgl;
  assign err_fatal     = dbl;
endmodule

// File: rtl/hd3_pattern_fsm_chk.sv
module hd3_pattern_fsm_chk
  import hd3_pkg::*;
#(
  parameter logic [KEY_W-1:0] KEY = 16'hA5A5
) (
  input logic clk,
  input logic rst,
  input logic detect,
  input logic err_corrected,
  input logic err_fatal,
  input logic vld_q,
  input idx_t idx
);
  // R8
  reset_clean_chk: assert property (@(posedge clk)
    rst |=> (!detect && !err_corrected && !err_fatal));

  // R6
  scrub_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    err_corrected |=> !err_corrected);

  // R7
  fatal_restart_chk: assert property (@(posedge clk) disable iff (rst)
    err_fatal |=> (!err_fatal && idx == '0 && !detect));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!vld_q && !err_fatal) |=> (err_fatal || idx == $past(idx)));

  if (KEY != '0 && KEY != '1) begin : g_gap
    // R1
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      detect |=> !detect);
  end
endmodule

bind hd3_pattern_fsm hd3_pattern_fsm_chk #(.KEY(KEY)) u_chk (
  .clk(clk), .rst(rst), .detect(detect), .err_corrected(err_corrected),
  .err_fatal(err_fatal), .vld_q(in_vld_q), .idx(cur_idx)
);

// File: tb/tb_hd3_pattern_fsm.sv
module tb_hd3_pattern_fsm;
  localparam int CLK_P = 10;
  localparam logic [15:0] KEY = 16'hA5A5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic bit_valid = 1'b0;
  logic bit_ready, detect, err_corrected, err_fatal;

  hd3_pattern_fsm #(.KEY(KEY)) dut (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_valid(bit_valid),
    .bit_ready(bit_ready), .detect(detect), .err_corrected(err_corrected),
    .err_fatal(err_fatal)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    logic  det;
    logic  corr;
    logic  fat;
    string tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model: accepted-bit history and count since reset or restart.
  logic [15:0] hist = '0;
  int cnt = 0;
  logic pb = 1'b0;
  logic pv = 1'b0;
  logic [7:0] fvec = '0;

  function automatic logic [7:0] tb_code(int k);
    logic [3:0] n;
    logic [7:0] c;
    n = 4'(k);
    c[3:0] = n;
    c[4] = n[0] ^ n[1] ^ n[3];
    c[5] = n[0] ^ n[2] ^ n[3];
    c[6] = n[1] ^ n[2] ^ n[3];
    c[7] = ^c[6:0];
    return c;
  endfunction

  function automatic int tb_prefix();
    for (int j = 15; j >= 1; j--) begin
      if (j <= cnt) begin
        if (((hist ^ (KEY >> (16 - j))) & ((16'(1) << j) - 16'(1))) == '0) return j;
      end
    end
    return 0;
  endfunction

  task automatic check3(string tag, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {detect,corrected,fatal} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Driver: one clock per call, pushes the expected outputs for this cycle.
  task automatic step(logic b, logic v, logic [7:0] mask, string tag);
    exp_t e;
    int k;
    int n;
    @(negedge clk);
    k = tb_prefix();
    n = $countones(mask);
    if (mask != '0) begin
      fvec = tb_code(k) ^ mask;
      force dut.state_q = fvec;
      #1;
      release dut.state_q;
    end
    e.tag = tag;
    e.det = 1'b0;
    if (n >= 2) begin
      e.corr = 1'b0;
      e.fat  = 1'b1;
      hist = '0;
      cnt = 0;
    end else begin
      e.corr = (n == 1);
      e.fat  = 1'b0;
      if (pv) begin
        hist = {hist[14:0], pb};
        cnt++;
        e.det = (cnt >= 16) && (hist == KEY);
      end
    end
    sb.push_back(e);
    pb = b;
    pv = v;
    bit_in = b;
    bit_valid = v;
  endtask

  task automatic send_word(logic [15:0] w, string tag);
    for (int i = 15; i >= 0; i--) step(w[i], 1'b1, 8'h00, tag);
  endtask

  task automatic flush();
    for (int i = 0; i < 16; i++) step(1'b0, 1'b1, 8'h00, "R3");
  endtask

  task automatic send_inj(int pos, logic [7:0] mask, string tag);
    for (int i = 0; i <= 16; i++) begin
      step((i < 16) ? KEY[15-i] : 1'b0, 1'b1, (i == pos) ? mask : 8'h00, tag);
    end
  endtask

  // Monitor: compares each cycle against the queued expectation.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        check3(e.tag, {detect, err_corrected, err_fatal}, {e.det, e.corr, e.fat});
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_up();
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    // R8 reset state
    check3("R8 reset outputs", {detect, err_corrected, err_fatal}, 3'b000);
    checks++;
    if (bit_ready !== 1'b0) begin
      errors++;
      $display("FAIL R8 bit_ready in reset: actual=%b expected=0", bit_ready);
    end
    rst = 1'b0;
    @(negedge clk);
    #2;
    checks++;
    if (bit_ready !== 1'b1) begin
      errors++;
      $display("FAIL R8 bit_ready after reset: actual=%b expected=1", bit_ready);
    end
    check3("R8 after reset", {detect, err_corrected, err_fatal}, 3'b000);

    send_word(KEY, "R1");
    flush();
    send_word(KEY, "R2");
    for (int i = 7; i >= 0; i--) step(KEY[i], 1'b1, 8'h00, "R2");
    flush();
    send_word(KEY ^ 16'h0001, "R3");
    flush();
    send_word(KEY ^ 16'h0080, "R3");
    flush();
    send_word(KEY ^ 16'h8000, "R3");
    flush();
    for (int i = 0; i < 16; i++) begin
      step(KEY[15-i], 1'b1, 8'h00, "R4");
      step(~KEY[15-i], 1'b0, 8'h00, "R4");
      step(1'b1, 1'b0, 8'h00, "R4");
    end
    flush();
    for (int b = 0; b < 8; b++) begin
      send_inj(b * 2, 8'(1) << b, "R6");
      flush();
    end
    send_inj(16, 8'h80, "R6");
    send_inj(15, 8'h01, "R5");
    flush();
    send_inj(8, 8'h12, "R7");
    flush();
    send_inj(16, 8'h41, "R7");
    send_word(KEY, "R7");
    send_inj(0, 8'h03, "R7");
    flush();

    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      if (i % 500 == 250) send_word(KEY, "R2");
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[3] | lfsr[5], 8'h00, "R2");
    end
    repeat (4) step(1'b0, 1'b0, 8'h00, "R4");
    @(negedge clk);
    #3;
    finish_up();
  end
endmodule